// File: doc/BRIEF.md
# Dual-Role Synchronous Serial Port

This block is a full-duplex SPI port that runs as a bus master or as a bus slave. Software reaches it through a small word-wide register file. It holds two control words, a prescale value, a data window and a status word. Each word placed in the data window goes into an 8-entry transmit queue. The shift engine sends that word most significant bit first. At the same time it collects the word arriving on the opposite line and stores it in an 8-entry receive queue, where software reads it back.

Frames can be 4 to 16 bits long and use any of the four clock polarity and phase modes. In master mode the port makes the serial clock from two cascaded dividers and drives an active-low select for each frame. In slave mode it brings the external clock, select and data into the peripheral clock domain and counts edges. A loopback setting joins the transmit shifter to the receive shifter inside the block. A slave output-disable setting turns off the slave data driver.

Top module: `spi_port`

## Requirements
- R1: After reset the control word 0 reads 0x0007 (8-bit frames, mode 0), control word 1 reads 0, the prescale register reads 2, and the status word reads 0x0002.
- R2: The register addresses are: 0 for control word 0, 1 for control word 1, 2 for the prescale register, 3 for the data window and 4 for the status word. Control word 0 holds the frame length minus one in [3:0], the format in [5:4] (only 0, SPI, is accepted), the clock polarity in bit 6, the clock phase in bit 7 and the divider D in [15:8]. Control word 1 holds loopback in bit 0, enable in bit 1, slave role in bit 2 and slave output disable in bit 3.
- R3: Writes to control word 0 or to the prescale register are ignored while the enable bit is set. A control word 0 write is ignored if its length field is below 3 or its format field is nonzero. A prescale write is ignored if the value is odd or zero.
- R4: Status bit 1 is set when the transmit queue is not full. Status bit 2 is set when the receive queue is not empty. Status bit 4 is set while a frame is being shifted. All other status bits read 0.
- R5: In master loopback mode, an N-bit frame (N from 4 to 16, in any mode) stores the low N bits of the transmitted word in the receive queue, and miso_i has no effect. Without loopback, the received word is the one sampled on miso_i.
- R6: In master mode, a frame produces exactly 2N serial clock edges. The clock idles at the polarity level. With phase 0 the data is sampled on leading edges, and with phase 1 on trailing edges. mosi_o carries the word MSB first at each sampling edge. ssel_o stays low from the start of the frame until the final clock edge, which releases it.
- R7: In master mode, every serial clock half-period after the first lasts P*(D+1)/2 peripheral clocks, where P is the prescale value.
- R8: Each queue holds 8 words. A data write to a full transmit queue is dropped. A received word that finds the receive queue full is discarded.
- R9: In slave mode, a frame starts when ssel_i falls. The port samples mosi_i MSB first according to the mode, presents the queued transmit word MSB first on miso_o, and drives miso_oe_o while it is selected. The serial clock must not exceed one twelfth of the peripheral clock.
- R10: When slave output disable is set, miso_oe_o stays low, but the received word is still stored.
- R11: A read of the data window returns the oldest received word and removes it. A read with an empty receive queue returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (pops the receive queue at address 3) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| sck_o | output | 1 | Master serial clock |
| ssel_o | output | 1 | Master select, active low |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| sck_i | input | 1 | Slave serial clock in |
| ssel_i | input | 1 | Slave select in, active low |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe_o | output | 1 | Slave data output enable |

## Verification
The bench uses the default 16-bit width and 8-deep queues. With the prescale at 2 and D at 0, a master frame lasts only a few dozen cycles. That is short enough to sweep every legal frame length against all four modes in loopback, checking the edge count, the MOSI bit order and the received word for each pair. It then widens the dividers to two other settings to measure the half-period. In the slave runs it drives the external clock at one sixteenth of the peripheral rate, with every mode and two frame lengths. A queue depth of 8 lets both overflow paths be reached with nine words.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef enum logic [2:0] {
    A_CTRL0 = 3'd0,
    A_CTRL1 = 3'd1,
    A_PRESC = 3'd2,
    A_DATA  = 3'd3,
    A_STAT  = 3'd4
  } reg_addr_e;

  localparam logic [15:0] CTRL0_RST = 16'h0007;
  localparam logic [7:0]  PRESC_RST = 8'd2;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = cnt_q == CW'(DEPTH);
  assign empty_o = cnt_q == '0;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  p_full_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(cnt_q));
  p_empty_pop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int PW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [PW-1:0] presc_i,
  input  logic [DW-1:0] div_i,
  output logic          tick_o
);
  localparam int HW = PW + DW;

  logic [HW-1:0] half, cnt_q;

  // half period = (P/2)*(D+1) peripheral clocks
  assign half = HW'(presc_i[PW-1:1]) * (HW'(div_i) + HW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= half - HW'(1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + HW'(1);
      tick_o <= 1'b0;
    end
  end

  p_tick_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && half > HW'(1) && $stable(half)) |=> !tick_o);
endmodule

// File: rtl/spi_engine.sv
module spi_engine #(
  parameter int W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 slave_i,
  input  logic                 lbm_i,
  input  logic                 cpol_i,
  input  logic                 cpha_i,
  input  logic [$clog2(W)-1:0] len_m1_i,
  input  logic                 tick_i,
  input  logic                 tx_avail_i,
  input  logic [W-1:0]         tx_word_i,
  input  logic                 sck_s_i,
  input  logic                 ssel_s_i,
  input  logic                 din_ext_i,
  output logic                 tx_pop_o,
  output logic                 rx_push_o,
  output logic [W-1:0]         rx_word_o,
  output logic                 busy_o,
  output logic                 sck_o,
  output logic                 dout_o
);
  localparam int LW = $clog2(W);

  logic [W-1:0] tx_sr, rx_sr, rx_next;
  logic [LW:0]  hcnt;
  logic         sck_q, sck_prev_q, ssel_prev_q;
  logic         lead, smp, shft, step, last, start, abort, din;

  assign dout_o = tx_sr[len_m1_i];
  assign din    = lbm_i ? dout_o : din_ext_i;
  assign busy_o = busy_q;
  assign sck_o  = sck_q;

  logic busy_q;

  always_comb begin
    lead    = ~hcnt[0];
    smp     = cpha_i ? ~lead : lead;
    shft    = cpha_i ? (lead && hcnt != '0) : ~lead;
    step    = busy_q && (slave_i ? (sck_s_i ^ sck_prev_q) : tick_i);
    last    = hcnt == {len_m1_i, 1'b1};
    start   = !busy_q && en_i && (slave_i ? (ssel_prev_q && !ssel_s_i) : tx_avail_i);
    abort   = busy_q && slave_i && ssel_s_i;
    rx_next = {rx_sr[W-2:0], din};
  end

  assign tx_pop_o  = start && tx_avail_i;
  assign rx_push_o = step && last && !abort;
  assign rx_word_o = smp ? rx_next : rx_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      tx_sr       <= '0;
      rx_sr       <= '0;
      hcnt        <= '0;
      sck_q       <= 1'b0;
      sck_prev_q  <= 1'b0;
      ssel_prev_q <= 1'b1;
    end else begin
      sck_prev_q  <= sck_s_i;
      ssel_prev_q <= ssel_s_i;
      if (start) begin
        busy_q <= 1'b1;
        tx_sr  <= tx_avail_i ? tx_word_i : '0;
        rx_sr  <= '0;
        hcnt   <= '0;
        sck_q  <= cpol_i;
      end else if (abort) begin
        busy_q <= 1'b0;
        sck_q  <= cpol_i;
      end else if (step) begin
        if (smp)  rx_sr <= rx_next;
        if (shft) tx_sr <= {tx_sr[W-2:0], 1'b0};
        sck_q <= ~sck_q;
        hcnt  <= hcnt + 1'b1;
        if (last) busy_q <= 1'b0;
      end else if (!busy_q) begin
        sck_q <= cpol_i;
      end
    end
  end

  p_end_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_q) && !slave_i && $stable(cpol_i)) |-> (sck_q == cpol_i));
  p_idle_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !$past(busy_q) && $stable(cpol_i)) |-> (sck_q == cpol_i));
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        sck_o,
  output logic        ssel_o,
  output logic        mosi_o,
  input  logic        miso_i,
  input  logic        sck_i,
  input  logic        ssel_i,
  input  logic        mosi_i,
  output logic        miso_o,
  output logic        miso_oe_o
);
  localparam int LW = $clog2(W);

  logic [15:0] ctrl0_q;
  logic [3:0]  ctrl1_q;
  logic [7:0]  presc_q;
  logic [1:0]  sck_sy, ssel_sy, mosi_sy;
  logic        en, slave, lbm, sod, cpol, cpha;
  logic        tx_full, tx_empty, rx_full, rx_empty;
  logic        tx_pop, rx_push, busy, tick, eng_sck, dout;
  logic [W-1:0] tx_word, rx_word, rx_head;
  reg_addr_e   addr;

  assign addr  = reg_addr_e'(addr_i);
  assign lbm   = ctrl1_q[0];
  assign en    = ctrl1_q[1];
  assign slave = ctrl1_q[2];
  assign sod   = ctrl1_q[3];
  assign cpol  = ctrl0_q[6];
  assign cpha  = ctrl0_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl0_q <= CTRL0_RST;
      ctrl1_q <= '0;
      presc_q <= PRESC_RST;
      sck_sy  <= '0;
      ssel_sy <= '1;
      mosi_sy <= '0;
    end else begin
      sck_sy  <= {sck_sy[0], sck_i};
      ssel_sy <= {ssel_sy[0], ssel_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
      if (wr_i) begin
        unique case (addr)
          A_CTRL0: if (!en && wdata_i[3:0] >= 4'd3 && wdata_i[5:4] == 2'b00) ctrl0_q <= wdata_i;
          A_CTRL1: ctrl1_q <= wdata_i[3:0];
          A_PRESC: if (!en && !wdata_i[0] && wdata_i[7:0] != 8'd0) presc_q <= wdata_i[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL0: rdata_o = ctrl0_q;
      A_CTRL1: rdata_o = {12'd0, ctrl1_q};
      A_PRESC: rdata_o = {8'd0, presc_q};
      A_DATA:  rdata_o = rx_empty ? 16'd0 : 16'(rx_head);
      A_STAT:  rdata_o = {11'd0, busy, 1'b0, !rx_empty, !tx_full, 1'b0};
      default: rdata_o = 16'd0;
    endcase
  end

  spi_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i (wr_i && addr == A_DATA),
    .wdata_i(W'(wdata_i)),
    .pop_i  (tx_pop),
    .rdata_o(tx_word),
    .full_o (tx_full),
    .empty_o(tx_empty)
  );

  spi_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .push_i (rx_push),
    .wdata_i(rx_word),
    .pop_i  (rd_i && addr == A_DATA),
    .rdata_o(rx_head),
    .full_o (rx_full),
    .empty_o(rx_empty)
  );

  spi_clkgen #(.PW(8), .DW(8)) u_clk (
    .clk_i, .rst_ni,
    .run_i  (busy && !slave),
    .presc_i(presc_q),
    .div_i  (ctrl0_q[15:8]),
    .tick_o (tick)
  );

  spi_engine #(.W(W)) u_eng (
    .clk_i, .rst_ni,
    .en_i      (en),
    .slave_i   (slave),
    .lbm_i     (lbm),
    .cpol_i    (cpol),
    .cpha_i    (cpha),
    .len_m1_i  (ctrl0_q[LW-1:0]),
    .tick_i    (tick),
    .tx_avail_i(!tx_empty),
    .tx_word_i (tx_word),
    .sck_s_i   (sck_sy[1]),
    .ssel_s_i  (ssel_sy[1]),
    .din_ext_i (slave ? mosi_sy[1] : miso_i),
    .tx_pop_o  (tx_pop),
    .rx_push_o (rx_push),
    .rx_word_o (rx_word),
    .busy_o    (busy),
    .sck_o     (eng_sck),
    .dout_o    (dout)
  );

  assign sck_o     = slave ? cpol : eng_sck;
  assign ssel_o    = !(busy && !slave);
  assign mosi_o    = slave ? 1'b0 : dout;
  assign miso_o    = dout;
  assign miso_oe_o = en && slave && !sod && !ssel_sy[1];

  p_cfg_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && $past(en)) |-> ($stable(ctrl0_q) && $stable(presc_q)));
  p_sod_hiz_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sod |-> !miso_oe_o);
  p_rx_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && rx_full && !(rd_i && addr == A_DATA)) |=> rx_full);
endmodule

// File: tb/spi_port_tb.sv
module spi_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        sck_o, ssel_o, mosi_o, miso_i, miso_o, miso_oe_o;
  logic        sck_i = 1'b0, ssel_i = 1'b1, mosi_i = 1'b0;
  logic        inv_loop = 1'b0;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  assign miso_i = inv_loop ? ~mosi_o : 1'b1;

  spi_port dut_i (
    .clk_i(clk), .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .sck_o, .ssel_o, .mosi_o, .miso_i, .sck_i, .ssel_i, .mosi_i,
    .miso_o, .miso_oe_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr_i = 3'(a); wdata_i = 16'(d); wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    addr_i = 3'(a); rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  function automatic logic [15:0] msk(input int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  task automatic cfg(input int n, input int mode, input int p, input int d, input int c1);
    wr(1, 0);
    wr(0, (d << 8) | ((mode & 1) << 7) | (((mode >> 1) & 1) << 6) | (n - 1));
    wr(2, p);
    wr(1, c1);
  endtask

  // master frame with monitor of SCK/SSEL/MOSI
  task automatic mframe(input logic [15:0] w, input int n, input int mode, input int half,
                        input logic [15:0] exp_rx);
    logic cpol, cpha, prev, cur;
    logic [15:0] cap, got;
    int edges, ssel_hi, last_t, bad_half;
    bit started;
    cpol = mode[1]; cpha = mode[0];
    cap = '0; edges = 0; ssel_hi = 0; last_t = -1; bad_half = 0; started = 0;
    prev = sck_o;
    wr(3, w);
    for (int t = 0; t < 20000; t++) begin
      @(negedge clk);
      cur = sck_o;
      if (!ssel_o) started = 1;
      if (cur != prev) begin
        edges++;
        if (ssel_o) ssel_hi++;
        if (last_t >= 0 && t - last_t != half) bad_half = 1;
        last_t = t;
        if ((cur != cpol) == !cpha) cap = {cap[14:0], mosi_o};
      end
      prev = cur;
      if (started && ssel_o) break;
    end
    chk(edges == 2*n, "R6 edge count", edges, 2*n);
    chk(ssel_hi == 1, "R6 select held to last edge", ssel_hi, 1);
    chk((cap & msk(n)) == (w & msk(n)), "R6 mosi msb first", cap & msk(n), w & msk(n));
    chk(bad_half == 0, "R7 half period", bad_half, 0);
    chk(sck_o == cpol, "R6 idle level", sck_o, cpol);
    repeat (2) @(negedge clk);
    rd(3, got);
    chk(got == exp_rx, "R5 received word", got, exp_rx);
  endtask

  task automatic sframe(input logic [15:0] w, input int n, input int mode,
                        output logic [15:0] got, output int oe_seen);
    logic cpol, cpha;
    cpol = mode[1]; cpha = mode[0];
    got = '0; oe_seen = 0;
    sck_i = cpol;
    repeat (8) @(negedge clk);
    ssel_i = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      if (!cpha) begin
        mosi_i = w[i];
        repeat (8) @(negedge clk);
        got = {got[14:0], miso_o}; oe_seen += miso_oe_o;
        sck_i = ~cpol;
        repeat (8) @(negedge clk);
        sck_i = cpol;
      end else begin
        sck_i = ~cpol; mosi_i = w[i];
        repeat (8) @(negedge clk);
        got = {got[14:0], miso_o}; oe_seen += miso_oe_o;
        sck_i = cpol;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    ssel_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, w, got;
    int oe;
    logic [15:0] saved [8];
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(0, v); chk(v == 16'h0007, "R1 ctrl0 reset", v, 16'h0007);
    rd(1, v); chk(v == 16'h0000, "R1 ctrl1 reset", v, 0);
    rd(2, v); chk(v == 16'h0002, "R1 prescale reset", v, 2);
    rd(4, v); chk(v == 16'h0002, "R1/R4 status reset", v, 2);

    // R2/R3 config gating
    wr(0, 16'h05C9); rd(0, v); chk(v == 16'h05C9, "R2 ctrl0 write", v, 16'h05C9);
    wr(0, 16'h0002); rd(0, v); chk(v == 16'h05C9, "R3 short length ignored", v, 16'h05C9);
    wr(0, 16'h0017); rd(0, v); chk(v == 16'h05C9, "R3 format ignored", v, 16'h05C9);
    wr(2, 3);        rd(2, v); chk(v == 16'h0002, "R3 odd prescale ignored", v, 2);
    wr(2, 6);        rd(2, v); chk(v == 16'h0006, "R2 prescale write", v, 6);
    wr(1, 2);
    wr(0, 16'h0007); rd(0, v); chk(v == 16'h05C9, "R3 ctrl0 frozen when enabled", v, 16'h05C9);
    wr(2, 4);        rd(2, v); chk(v == 16'h0006, "R3 prescale frozen when enabled", v, 6);
    rd(1, v); chk(v == 16'h0002, "R2 ctrl1 readback", v, 2);

    // R5/R6 sweep: all lengths x all modes, loopback, miso_i held high
    for (int n = 4; n <= 16; n++) begin
      for (int m = 0; m < 4; m++) begin
        w = 16'hA5C3 ^ 16'(n * 16'h1357) ^ 16'(m * 16'h0F0F);
        cfg(n, m, 2, 0, 16'h3);
        mframe(w, n, m, 1, w & msk(n));
      end
    end

    // R5 external path: miso_i = ~mosi_o
    inv_loop = 1'b1;
    for (int m = 0; m < 4; m++) begin
      w = 16'h3C69 ^ 16'(m * 16'h1111);
      cfg(8, m, 2, 0, 16'h2);
      mframe(w, 8, m, 1, ~w & msk(8));
    end
    inv_loop = 1'b0;

    // R7 divider settings
    cfg(8, 0, 8, 0, 16'h3); mframe(16'h00B4, 8, 0, 4, 16'h00B4);
    cfg(8, 3, 4, 2, 16'h3); mframe(16'h005A, 8, 3, 6, 16'h005A);

    // R8/R4 queue limits
    cfg(8, 0, 2, 0, 16'h0);
    for (int i = 0; i < 9; i++) begin
      if (i < 8) saved[i] = 16'(8'h11 * (i + 1));
      wr(3, 8'h11 * (i + 1) + 1);
      if (i < 8) saved[i] = 16'((8'h11 * (i + 1) + 1) & 8'hFF);
      if (i == 7) begin
        rd(4, v); chk(v == 16'h0000, "R4/R8 tx full flag", v, 0);
      end
    end
    wr(1, 3);
    repeat (300) @(negedge clk);
    rd(4, v); chk(v == 16'h0006, "R4 rx not empty flag", v, 6);
    wr(3, 16'h00EE);
    repeat (60) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rd(3, v); chk(v == saved[i], "R8 queue order and drops", v, saved[i]);
    end
    rd(4, v); chk(v == 16'h0002, "R4 queues drained", v, 2);
    rd(3, v); chk(v == 16'h0000, "R11 empty read", v, 0);

    // R9 slave mode
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 2; k++) begin
        int n;
        n = k ? 12 : 8;
        w = 16'h9D2B ^ 16'(m * 16'h0707);
        cfg(n, m, 2, 0, 16'h0);
        wr(3, w);
        wr(1, 16'h6);
        sframe(16'h5A3C ^ 16'(m), n, m, got, oe);
        chk((got & msk(n)) == (w & msk(n)), "R9 miso bits", got & msk(n), w & msk(n));
        chk(oe == n, "R9 output enable", oe, n);
        repeat (4) @(negedge clk);
        rd(3, v);
        chk(v == ((16'h5A3C ^ 16'(m)) & msk(n)), "R9 slave receive", v, (16'h5A3C ^ 16'(m)) & msk(n));
      end
    end

    // R10 slave output disable
    cfg(8, 1, 2, 0, 16'h0);
    wr(3, 16'h0081);
    wr(1, 16'hE);
    sframe(16'h00C6, 8, 1, got, oe);
    chk(oe == 0, "R10 driver off", oe, 0);
    repeat (4) @(negedge clk);
    rd(3, v); chk(v == 16'h00C6, "R10 still receives", v, 16'h00C6);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule